// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a single-port synchronous static memory with flow-through reads. The address register, the operation type and the burst position are all captured on the rising clock. Read data comes straight out of the array in the cycle that follows the capturing edge. Write data is taken one edge after its address. Because of this, a read can follow a write on the very next edge and no idle cycle is needed.

The block has three chip selects of mixed polarity, a clock-enable that freezes the whole block, and an advance/load control. The advance/load control either starts an access or steps a two-bit burst counter. The burst counter walks the two lowest address bits in either incrementing or XOR order, and it wraps after four beats. The bidirectional data bus is split into three signals: `din`, `dout` and a drive flag `dq_drive`. The output enable acts on the drive flag without a clock.

The controller is a three-state machine with the states `ST_IDLE`, `ST_READ` and `ST_WRITE`. The transitions are:
- LOAD_RD: load with write-enable high, into `ST_READ`.
- LOAD_WR: load with write-enable low, into `ST_WRITE`.
- ADVANCE: advance/load high in `ST_READ` or `ST_WRITE`. The state stays the same and the beat steps.
- DESELECT: load while any chip select is inactive, into `ST_IDLE`.
- STALL: clock-enable high, so every register holds.
- An advance in `ST_IDLE` keeps the block in `ST_IDLE`.

Top module: `fts_sram`

## Requirements
- R1: After reset the block is in the idle state and `dq_drive` is 0.
- R2: An access starts at an edge only when all of these hold: `clk_en_n`=0, `sel1_n`=0, `sel2`=1, `sel3_n`=0 and `adv_ld_n`=0. At that edge `addr` is captured and the beat count returns to 0. A load attempted with `clk_en_n`=1 starts nothing.
- R3: After a read load edge, `dout` shows the word at the current burst address in that same cycle, with `dq_drive`=1 when `oe_n`=0.
- R4: During a write, `din` and `lane_wr_n` are sampled at the edge after the address. Bit i of `lane_wr_n` low writes byte i, which is bits [8i+7:8i]. A lane held high keeps its old byte. A read loaded on that same edge returns the new data.
- R5: The direction (`wr_n` at load time) holds for the whole burst. `wr_n` during advance cycles is ignored.
- R6: `adv_ld_n`=1 at an enabled edge steps the beat by one whatever the chip selects are. In the idle state an advance starts no access.
- R7: With `burst_ilv`=0 at load, the low two address bits are (start + beat) mod 4, the upper bits stay fixed, and the fifth beat wraps back to the start.
- R8: With `burst_ilv`=1 at load, the low two bits are start XOR beat. The mode is sampled only at load.
- R9: With `clk_en_n`=1 the edge is ignored. State, beat and address hold, and no pending write is committed.
- R10: A load with any chip select inactive makes the block idle, and `dq_drive` is 0 right after that edge.
- R11: `dq_drive` follows `oe_n` without a clock during a read. During a write data phase `dq_drive` is 0 whatever `oe_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Clock qualifier, low = edge is used |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low = write, high = read, sampled at load |
| adv_ld_n | input | 1 | Low = load new address, high = advance burst |
| burst_ilv | input | 1 | 0 = incrementing burst, 1 = XOR burst |
| lane_wr_n | input | LANES | Per-byte write selects, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | High when the bus is driven by the block |

## Verification
All results fall on the edge that registers the command, except write data. Read data and `dq_drive` are due in the cycle right after the load or advance edge. A deselect or write load clears `dq_drive` right after its edge. Write data lands in the array at the next enabled edge, so it becomes readable one cycle later through a read loaded on that edge. The bench changes inputs and samples outputs 2 ns after each rising edge. It checks `oe_n` effects within the same cycle, without a clock edge.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fts_state_e;

    // Low two address bits for a given beat of a burst.
    function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        return ilv ? (start ^ beat) : 2'(start + beat);
    endfunction

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              chip_ok,
    input  logic              wr_n,
    input  logic              adv_ld_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    output fts_state_e        state_q,
    output logic [1:0]        beat_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              commit_wr
);

    fts_state_e        state_d;
    logic [1:0]        beat_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              ilv_q, ilv_d;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        base_d  = base_q;
        ilv_d   = ilv_q;
        if (!clk_en_n) begin
            if (!adv_ld_n) begin
                if (chip_ok) begin
                    state_d = wr_n ? ST_READ : ST_WRITE;
                    base_d  = addr;
                    beat_d  = 2'd0;
                    ilv_d   = burst_ilv;
                end else begin
                    state_d = ST_IDLE;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE:           state_d = ST_IDLE;
                    ST_READ, ST_WRITE: beat_d  = 2'(beat_q + 2'd1);
                    default:           state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= 2'd0;
            base_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            ilv_q   <= ilv_d;
        end
    end

    always_comb begin
        cur_addr  = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], beat_q, ilv_q)};
        commit_wr = !clk_en_n && (state_q == ST_WRITE);
    end

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !lane_wr_n[g])
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    wr_n,
    input  logic                    adv_ld_n,
    input  logic                    burst_ilv,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dq_drive
);

    localparam int DATA_W = LANES * LANE_W;

    fts_state_e        state_q;
    logic [1:0]        beat_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              commit_wr;
    logic              chip_ok;
    logic [DATA_W-1:0] rdata;

    assign chip_ok = !sel1_n && sel2 && !sel3_n;

    fts_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .chip_ok   (chip_ok),
        .wr_n      (wr_n),
        .adv_ld_n  (adv_ld_n),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .state_q   (state_q),
        .beat_q    (beat_q),
        .cur_addr  (cur_addr),
        .commit_wr (commit_wr)
    );

    fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .wr_en     (commit_wr),
        .lane_wr_n (lane_wr_n),
        .addr      (cur_addr),
        .wdata     (din),
        .rdata     (rdata)
    );

    always_comb begin
        dq_drive = (state_q == ST_READ) && !oe_n;
        dout     = dq_drive ? rdata : '0;
    end

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk
    import fts_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en_n,
    input logic       sel1_n,
    input logic       sel2,
    input logic       sel3_n,
    input logic       wr_n,
    input logic       adv_ld_n,
    input logic       oe_n,
    input logic       dq_drive,
    input fts_state_e state_q,
    input logic [1:0] beat_q
);

    logic sel_ok;
    assign sel_ok = !sel1_n && sel2 && !sel3_n;

    assert_drive_needs_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !oe_n);

    assert_write_floats_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && sel_ok && !wr_n) |=> !dq_drive);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(state_q) && $stable(beat_q)));

    assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && !sel_ok) |=> (!dq_drive && state_q == ST_IDLE));

    assert_advance_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld_n && state_q != ST_IDLE) |=> beat_q == 2'($past(beat_q) + 2'd1));

    assert_dir_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld_n) |=> state_q == $past(state_q));

    assert_load_clears_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n && sel_ok) |=> beat_q == 2'd0);

endmodule

bind fts_sram fts_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .wr_n     (wr_n),
    .adv_ld_n (adv_ld_n),
    .oe_n     (oe_n),
    .dq_drive (dq_drive),
    .state_q  (state_q),
    .beat_q   (beat_q)
);

// File: tb/sim_fts_sram.sv
`timescale 1ns/1ps
module sim_fts_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
    logic        wr_n = 1'b1, adv_ld_n = 1'b0, burst_ilv = 1'b0;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [5:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dq_drive;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] ref_mem [64];

    always #5 clk = ~clk;

    fts_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .wr_n(wr_n), .adv_ld_n(adv_ld_n),
        .burst_ilv(burst_ilv), .lane_wr_n(lane_wr_n), .addr(addr),
        .oe_n(oe_n), .din(din), .dout(dout), .dq_drive(dq_drive)
    );

    function automatic logic [5:0] baddr(input logic [5:0] b, input int beat, input logic ilv);
        logic [1:0] bt = 2'(beat);
        return {b[5:2], ilv ? (b[1:0] ^ bt) : 2'(b[1:0] + bt)};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] ln);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (!ln[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic ld(input logic is_wr, input logic [5:0] a, input logic ilv);
        clk_en_n = 0; sel1_n = 0; sel2 = 1; sel3_n = 0;
        wr_n = ~is_wr; adv_ld_n = 0; addr = a; burst_ilv = ilv;
        tick();
    endtask

    task automatic desel(input logic [31:0] d, input logic [3:0] ln);
        clk_en_n = 0; sel1_n = 1; adv_ld_n = 0; din = d; lane_wr_n = ln;
        tick();
    endtask

    task automatic adv(input logic [31:0] d, input logic [3:0] ln);
        clk_en_n = 0; adv_ld_n = 1; din = d; lane_wr_n = ln;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 drive after reset", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_write_then_read();
        ld(1, 6'd5, 0);
        chk("R11 write phase no drive", {31'd0, dq_drive}, 32'd0);
        din = 32'h1234_5678; lane_wr_n = 4'h0;
        ld(0, 6'd5, 0);
        ref_mem[5] = 32'h1234_5678;
        chk("R4 back-to-back read drive", {31'd0, dq_drive}, 32'd1);
        chk("R3 R4 read after write", dout, ref_mem[5]);
    endtask

    task automatic t_byte_mask();
        ld(1, 6'd6, 0);
        desel(32'h1122_3344, 4'h0);
        ref_mem[6] = 32'h1122_3344;
        ld(1, 6'd6, 0);
        din = 32'hAABB_CCDD; lane_wr_n = 4'b1010;
        ld(0, 6'd6, 0);
        ref_mem[6] = merge(ref_mem[6], 32'hAABB_CCDD, 4'b1010);
        chk("R4 lane mask", dout, 32'h11BB_33DD);
    endtask

    task automatic t_bursts();
        ld(1, 6'd9, 0);
        for (int b = 0; b < 3; b++) begin
            wr_n = 1;
            adv(32'hC000_0000 + b, 4'h0);
            ref_mem[baddr(6'd9, b, 0)] = 32'hC000_0000 + b;
            chk("R5 R11 write burst no drive", {31'd0, dq_drive}, 32'd0);
        end
        desel(32'hC000_0003, 4'h0);
        ref_mem[baddr(6'd9, 3, 0)] = 32'hC000_0003;
        ld(0, 6'd9, 0);
        chk("R7 linear beat0", dout, ref_mem[9]);
        for (int b = 1; b < 5; b++) begin
            wr_n = 0;
            adv(32'hFFFF_FFFF, 4'h0);
            chk("R7 R5 linear beat", dout, ref_mem[baddr(6'd9, b, 0)]);
        end
        chk("R7 wrap to start", dout, ref_mem[9]);
        ld(0, 6'd9, 1);
        chk("R8 ilv beat0", dout, ref_mem[9]);
        for (int b = 1; b < 4; b++) begin
            burst_ilv = 0;
            adv(32'h0, 4'hF);
            chk("R8 ilv beat", dout, ref_mem[baddr(6'd9, b, 1)]);
        end
        chk("R8 ilv last is addr 10", dout, ref_mem[10]);
        desel(32'h0, 4'hF);
        chk("R10 deselect floats", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_stall();
        ld(0, 6'd9, 0);
        chk("R3 stall setup", dout, ref_mem[9]);
        clk_en_n = 1; adv_ld_n = 1; tick();
        clk_en_n = 1; adv_ld_n = 0; addr = 6'd5; tick();
        chk("R9 stall holds read", dout, ref_mem[9]);
        adv(32'h0, 4'hF);
        chk("R9 resume advance", dout, ref_mem[10]);
        ld(1, 6'd20, 0);
        clk_en_n = 1; din = 32'hDEAD_BEEF; lane_wr_n = 4'h0; tick();
        desel(32'h5A5A_0001, 4'h0);
        ref_mem[20] = 32'h5A5A_0001;
        din = 32'h0; lane_wr_n = 4'hF;
        ld(0, 6'd20, 0);
        chk("R9 no commit in stall", dout, ref_mem[20]);
    endtask

    task automatic t_enables();
        ld(0, 6'd9, 0);
        sel1_n = 1;
        adv(32'h0, 4'hF);
        chk("R6 advance ignores selects", dout, ref_mem[10]);
        desel(32'h0, 4'hF);
        sel1_n = 0;
        adv(32'h0, 4'hF);
        chk("R6 idle advance no access", {31'd0, dq_drive}, 32'd0);
        clk_en_n = 0; sel1_n = 0; sel2 = 0; sel3_n = 0; wr_n = 1; adv_ld_n = 0; tick();
        chk("R10 R2 sel2 low no access", {31'd0, dq_drive}, 32'd0);
        sel2 = 1; clk_en_n = 1; tick();
        chk("R2 disabled clock no load", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_oe();
        oe_n = 1;
        ld(0, 6'd5, 0);
        chk("R11 oe high no drive", {31'd0, dq_drive}, 32'd0);
        #1 oe_n = 0;
        #1;
        chk("R11 oe async drive", {31'd0, dq_drive}, 32'd1);
        chk("R3 data under oe", dout, ref_mem[5]);
        desel(32'h0, 4'hF);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = 'x;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        t_reset();
        t_write_then_read();
        t_byte_mask();
        t_bursts();
        t_stall();
        t_enables();
        t_oe();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule